// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter with Chained TDM Slots

This block serialises one stereo sample pair per frame onto a single data line. The frame can use one of four framings: left-justified, I2S, right-justified, or a time-division frame shared by several chained transmitters. The output word length can be 24, 20, 18 or 16 bits. The most significant part of each 24-bit input sample is sent, and all unused bit positions are driven low. Outside TDM a frame is 64 bit clocks long, with 32 bits for each channel.

In TDM each transmitter sends its own 64-bit sub-frame first: left in the first 32 bits, right in the next 32, each left-justified. For the rest of the frame it sends the bits it received on its chain input 64 bit times earlier. Devices wired in a daisy chain therefore fill one frame of `NDEV` × 64 bits, with the device nearest the receiver occupying the first slot.

The port runs either as a slave or as a master. As a slave it follows an externally supplied bit clock and word clock, which are synchronised into the system clock domain. As a master it generates both clocks from a reference clock, which is presented as a strobe `ref_tick` pulsing once per reference-clock half period. Everything runs on the single system clock `clk`. Data and the master word clock always change just after a falling bit-clock edge, so a receiver samples on the rising edge.

Top module: `aud_ser_tx`

## Requirements
- R1: With `fmt` = 00 (left-justified), left is sent while the word clock is high and right while it is low. In each 32-bit half, sample bit 23 goes out on the first bit clock, and every bit after the selected word length is 0.
- R2: With `fmt` = 01 (I2S), left is sent while the word clock is low. In each half the first bit is 0, sample bit 23 follows on the second bit, and bits after the word length are 0.
- R3: With `fmt` = 11 (right-justified), the last sent sample bit falls on the 32nd bit of each half, and all bits before the word starts are 0.
- R4: `wlen` selects the word length: 00 gives 24 bits, 01 gives 20, 10 gives 18 and 11 gives 16. Only sample bits 23 down to 24 minus the length are sent.
- R5: With `fmt` = 10 (TDM), bit 0 of the frame is the bit clock on which the word clock is first high. Bits 0–31 carry left and bits 32–63 carry right, each left-justified and zero-filled.
- R6: In TDM, frame bit j ≥ 64 repeats the value of `tdm_in` sampled at frame bit j−64 of the same frame.
- R7: The port is master exactly when `mode[2]` = 0 and `mode[1:0]` ≠ 00, and `clk_drive` is high only then. In slave mode `bclk_out` and `wclk_out` stay low.
- R8: In master mode, outside TDM, `bclk_out` holds each level for 2, 8 or 4 `ref_tick` pulses when `mode[1:0]` is 01, 10 or 11 respectively. In TDM it holds each level for 1 pulse.
- R9: In master mode, outside TDM, the word clock toggles every 32 bit clocks. In TDM it is high for 32 bit clocks at the start of each frame of `NDEV` × 64 bits.
- R10: `sdata` and `wclk_out` change only right after a falling bit-clock edge.
- R11: Both samples of a frame are taken at the falling edge that starts frame bit 0. Later changes of `left_in` and `right_in` do not alter that frame.
- R12: While `rst_n` is low, `bclk_out`, `wclk_out` and `sdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | One pulse per reference-clock half period |
| mode | input | 3 | Port role and reference ratio select |
| fmt | input | 2 | Framing select |
| wlen | input | 2 | Output word length select |
| left_in | input | 24 | Left sample |
| right_in | input | 24 | Right sample |
| bclk_in | input | 1 | Bit clock from outside (slave) |
| wclk_in | input | 1 | Word clock from outside (slave) |
| tdm_in | input | 1 | Chain data from the upstream transmitter |
| bclk_out | output | 1 | Generated bit clock (master) |
| wclk_out | output | 1 | Generated word clock (master) |
| clk_drive | output | 1 | High when the clock outputs are to be driven |
| sdata | output | 1 | Serial data |

## Verification
The assertions assume that `mode`, `fmt` and `wlen` change only while reset is held. They also assume that in slave mode the external clocks hold each level for at least four system clocks, so that the synchroniser delays the bit clock, the word clock and the chain input by the same amount. The stimulus reprograms the block only inside a reset window. It runs the slave clocks at six system clocks per level and changes the word clock and chain data together with the falling bit-clock edge. In master mode it changes chain data only after it has observed the generated falling edge. It paces `ref_tick` at one pulse every four clocks, which keeps every master bit-clock level longer than the synchroniser latency.

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
  parameter int NDEV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick,
  input  logic [2:0]  mode,
  input  logic [1:0]  fmt,
  input  logic [1:0]  wlen,
  input  logic [23:0] left_in,
  input  logic [23:0] right_in,
  input  logic        bclk_in,
  input  logic        wclk_in,
  input  logic        tdm_in,
  output logic        bclk_out,
  output logic        wclk_out,
  output logic        clk_drive,
  output logic        sdata
);
  localparam int SLOT = 32;
  localparam int SUB  = 2 * SLOT;
  localparam int TFR  = NDEV * SUB;
  localparam int CW   = $clog2(TFR);

  localparam logic [1:0] F_LJ = 2'b00, F_I2S = 2'b01, F_TDM = 2'b10, F_RJ = 2'b11;

  wire master = ~mode[2] & (|mode[1:0]);
  wire is_tdm = (fmt == F_TDM);
  wire is_i2s = (fmt == F_I2S);
  assign clk_drive = master;

  logic [4:0] wb;
  always_comb
    case (wlen)
      2'b00:   wb = 5'd24;
      2'b01:   wb = 5'd20;
      2'b10:   wb = 5'd18;
      default: wb = 5'd16;
    endcase

  logic [3:0] half;
  always_comb
    if (is_tdm) half = 4'd1;
    else
      case (mode[1:0])
        2'b10:   half = 4'd8;
        2'b11:   half = 4'd4;
        default: half = 4'd2;
      endcase

  // two-stage synchroniser: bit clock, word clock, chain data
  logic [2:0] sy1, sy2;
  logic       bclk_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; bclk_d <= 1'b0;
    end else begin
      sy1 <= {bclk_in, wclk_in, tdm_in};
      sy2 <= sy1;
      bclk_d <= sy2[2];
    end
  wire bclk_s = sy2[2];
  wire wclk_s = sy2[1];
  wire tdm_s  = sy2[0];

  logic [3:0] hcnt;
  logic       mbclk;
  wire mtog  = master & ref_tick & (hcnt == half - 4'd1);
  wire bfall = master ? (mtog & mbclk)  : (bclk_d & ~bclk_s);
  wire brise = master ? (mtog & ~mbclk) : (~bclk_d & bclk_s);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hcnt <= '0; mbclk <= 1'b0;
    end else if (master && ref_tick) begin
      if (hcnt == half - 4'd1) begin
        hcnt  <= '0;
        mbclk <= ~mbclk;
      end else hcnt <= hcnt + 4'd1;
    end
  assign bclk_out = mbclk;

  logic [CW-1:0] cnt, nxt, flast;
  logic          wprev;
  assign flast = is_tdm ? CW'(TFR - 1) : CW'(SUB - 1);

  always_comb
    if (master)                 nxt = (cnt >= flast) ? '0 : cnt + 1'b1;
    else if (is_tdm)            nxt = (wclk_s & ~wprev) ? '0 : cnt + 1'b1;
    else if (wclk_s != wprev)   nxt = (wclk_s ^ is_i2s) ? '0 : CW'(SLOT);
    else                        nxt = cnt + 1'b1;

  logic [23:0]    llat, rlat, word;
  logic [SUB-1:0] chain;
  logic [4:0]     kk, idx, off;
  logic           ok, bit_nx;

  assign word = (nxt == '0) ? left_in : (nxt[5] ? rlat : llat);
  assign kk   = nxt[4:0];
  assign off  = 5'(6'd32 - {1'b0, wb});

  always_comb begin
    case (fmt)
      F_I2S: begin ok = (kk != 5'd0) && (kk <= wb); idx = 5'd24 - kk; end
      F_RJ:  begin ok = (kk >= off);                idx = 5'd23 - (kk - off); end
      default: begin ok = (kk < wb);                idx = 5'd23 - kk; end
    endcase
    bit_nx = ok ? word[idx] : 1'b0;
    if (is_tdm && (nxt >= CW'(SUB))) bit_nx = chain[SUB-1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '1; wprev <= 1'b0; sdata <= 1'b0; wclk_out <= 1'b0;
      llat <= '0; rlat <= '0;
    end else if (bfall) begin
      cnt   <= nxt;
      wprev <= wclk_s;
      sdata <= bit_nx;
      if (master) wclk_out <= (nxt < CW'(SLOT)) ^ is_i2s;
      if (nxt == '0) begin
        llat <= left_in;
        rlat <= right_in;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) chain <= '0;
    else if (brise) chain <= {chain[SUB-2:0], tdm_s};

endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_tick,
  input logic bclk_out,
  input logic wclk_out,
  input logic clk_drive,
  input logic sdata
);
  logic        wq, bq, seen;
  logic [15:0] ctr;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wq <= 1'b0; bq <= 1'b0; seen <= 1'b0; ctr <= '0;
    end else begin
      wq <= wclk_out;
      bq <= bclk_out;
      if (!wq && wclk_out) begin
        seen <= 1'b1;
        ctr  <= '0;
      end else if (bq && !bclk_out) ctr <= ctr + 16'd1;
    end

  // R10
  sdata_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_drive && !$fell(bclk_out)) |-> $stable(sdata));

  // R7
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_drive |-> (!bclk_out && !wclk_out));

  // R8
  bclk_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ref_tick) |-> $stable(bclk_out));

  // R10
  wclk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wclk_out != wq) |-> (bq && !bclk_out));

  // R9
  wclk_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wq && !wclk_out && seen) |-> (ctr == 16'd31));
endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bclk_out(bclk_out),
  .wclk_out(wclk_out), .clk_drive(clk_drive), .sdata(sdata)
);

// File: tb/tb_aud_ser_tx.sv
module tb_aud_ser_tx;
  localparam int NDEV = 4;
  localparam int HS = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, ref_tick = 1'b0, bclk_in = 1'b0, wclk_in = 1'b0, tdm_in = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [1:0] fmt = 2'b00, wlen = 2'b00;
  logic [23:0] left_in = '0, right_in = '0;
  logic bclk_out, wclk_out, clk_drive, sdata;

  aud_ser_tx #(.NDEV(NDEV)) dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .mode(mode), .fmt(fmt), .wlen(wlen),
    .left_in(left_in), .right_in(right_in), .bclk_in(bclk_in), .wclk_in(wclk_in),
    .tdm_in(tdm_in), .bclk_out(bclk_out), .wclk_out(wclk_out), .clk_drive(clk_drive),
    .sdata(sdata)
  );

  int checks = 0, errors = 0;
  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  bit [31:0] rs = 32'h1badcafe;
  task automatic roll();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
  endtask

  // reference model state
  bit started, prev_w, prev_b, prev_sd, chan;
  int k, j, frames, tcnt, gcnt, gdiv, tdiv;
  logic [23:0] lv, rv;
  logic hist [NDEV*64];

  function automatic int wbits(logic [1:0] c);
    case (c) 2'b00: return 24; 2'b01: return 20; 2'b10: return 18; default: return 16; endcase
  endfunction
  function automatic int half_ticks(logic [2:0] m, logic [1:0] f);
    if (f == 2'b10) return 1;
    case (m[1:0]) 2'b01: return 2; 2'b10: return 8; default: return 4; endcase
  endfunction
  function automatic bit exp_bit(logic [1:0] f, int w, int kk, logic [23:0] d);
    case (f)
      2'b01:   return (kk >= 1 && kk <= w) ? d[24-kk] : 1'b0;
      2'b11:   return (kk >= 32 - w) ? d[23-(kk-32+w)] : 1'b0;
      default: return (kk < w) ? d[23-kk] : 1'b0;
    endcase
  endfunction
  function automatic bit lvl(int g, logic [1:0] f);
    if (f == 2'b01) return g >= 32;
    return g < 32;
  endfunction

  task automatic new_samples();
    roll(); left_in = rs[23:0];
    roll(); right_in = rs[23:0];
  endtask

  task automatic rx(bit w, bit is_m, int fr);
    bit tdm = (fmt == 2'b10);
    bit e;
    if (tdm) begin
      if (w && !prev_w) begin
        if (started && is_m) chk(j == fr - 1, "R9 frame length", j + 1, fr);
        j = 0; started = 1; frames++;
        lv = left_in; rv = right_in; new_samples();
      end else j++;
      if (started && j < fr) begin
        hist[j] = tdm_in;
        if (j < 64) begin
          e = exp_bit(2'b00, wbits(wlen), j % 32, (j < 32) ? lv : rv);
          chk(sdata == e, "R5 R4 own slot", int'(sdata), int'(e));
        end else begin
          e = hist[j-64];
          chk(sdata == e, "R6 chain forward", int'(sdata), int'(e));
        end
      end
    end else begin
      if (w != prev_w) begin
        if (started && is_m) chk(k == 31, "R9 half length", k + 1, 32);
        k = 0;
        chan = !(w ^ (fmt == 2'b01));
        if (!chan) begin
          started = 1; frames++;
          lv = left_in; rv = right_in; new_samples();
        end
      end else k++;
      if (started && k < 32) begin
        string req;
        e = exp_bit(fmt, wbits(wlen), k, chan ? rv : lv);
        req = (fmt == 2'b00) ? "R1 R4" : (fmt == 2'b01) ? "R2 R4" : "R3 R4";
        if (chan) req = {req, " R11"};
        chk(sdata == e, req, int'(sdata), int'(e));
      end
    end
    prev_w = w;
  endtask

  task automatic step();
    bit is_m = !mode[2] && (mode[1:0] != 2'b00);
    int fr = (fmt == 2'b10) ? NDEV * 64 : 64;
    bit b, w;
    if (!rst_n) begin
      chk(!bclk_out && !wclk_out && !sdata, "R12 reset outputs",
          {bclk_out, wclk_out, sdata}, 0);
      started = 0; frames = 0; k = 0; j = 0; tcnt = 0; tdiv = 0; gdiv = 0;
      gcnt = fr - 1; ref_tick = 1'b0;
      bclk_in = 1'b0; tdm_in = 1'b0;
      wclk_in = is_m ? 1'b0 : lvl(gcnt, fmt);
      prev_w = is_m ? 1'b0 : wclk_in;
      prev_b = 1'b0; prev_sd = sdata;
      return;
    end
    if (!is_m) begin
      gdiv++;
      if (gdiv == HS) begin
        gdiv = 0;
        if (bclk_in) begin
          gcnt = (gcnt + 1) % fr;
          wclk_in = lvl(gcnt, fmt);
          roll(); tdm_in = rs[7];
          bclk_in = 1'b0;
        end else bclk_in = 1'b1;
      end
    end
    b = is_m ? bclk_out : bclk_in;
    w = is_m ? wclk_out : wclk_in;
    chk(clk_drive == is_m, "R7 role", int'(clk_drive), int'(is_m));
    if (!is_m) chk(!bclk_out && !wclk_out, "R7 slave clocks low", {bclk_out, wclk_out}, 0);
    if (is_m) begin
      if (ref_tick) tcnt++;
      if (b != prev_b) begin
        chk(tcnt == half_ticks(mode, fmt), "R8 bit clock level", tcnt, half_ticks(mode, fmt));
        tcnt = 0;
      end
    end
    if (sdata != prev_sd)
      chk(!b && (!is_m || prev_b), "R10 data edge", int'(b), 0);
    if (is_m && prev_b && !b) begin roll(); tdm_in = rs[9]; end
    if (!prev_b && b) rx(w, is_m, fr);
    prev_b = b; prev_sd = sdata;
    ref_tick = (tdiv == 3);
    tdiv = (tdiv + 1) % 4;
  endtask

  initial forever begin
    @(negedge clk);
    step();
  end

  task automatic run(logic [2:0] m, logic [1:0] f, logic [1:0] wl, int n);
    @(posedge clk); #2;
    rst_n = 1'b0; mode = m; fmt = f; wlen = wl;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    while (frames < n) @(posedge clk);
  endtask

  initial begin
    new_samples();
    run(3'b001, 2'b00, 2'b00, 3);  // master LJ 24
    run(3'b010, 2'b01, 2'b01, 3);  // master I2S 20
    run(3'b011, 2'b11, 2'b11, 3);  // master RJ 16
    run(3'b001, 2'b10, 2'b10, 3);  // master TDM 18
    run(3'b000, 2'b00, 2'b11, 3);  // slave LJ 16
    run(3'b100, 2'b01, 2'b00, 3);  // slave I2S 24
    run(3'b000, 2'b11, 2'b10, 3);  // slave RJ 18
    run(3'b100, 2'b10, 2'b00, 3);  // slave TDM 24
    run(3'b101, 2'b11, 2'b01, 2);  // input side master: output slave, RJ 20
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d frames expected progress", frames);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule